// File: doc/BRIEF.md
# Video Timing Output Formatter

This block sits between an internal raster generator and the device pins. Every pixel clock it takes the raw timing flags: horizontal and vertical sync, blanking, odd-field indicator, active-video and active-line qualifiers, a vertical-interval data flag, a pixel-rate strobe and a line-locked strobe. It turns them into the timing outputs seen outside the chip.

Each output has its own polarity select. A freeze request holds all timing outputs from the end of the current field, and they start moving again from the start of the next field after the request is dropped. The data-valid output has several shapes, and which one applies depends on the selected pixel output format: it can toggle at half the pixel clock rate, follow the line-lock strobe, span the whole line, or be gated by the clock itself.

Two output-enable signals are registered copies of configuration bits. Pad logic uses them to drive or float the pixel bus and the timing pins.

Top module: `vid_timing_fmt`

## Requirements
- R1: While reset is asserted and afterwards, until new timing is captured, the captured timing is all zero. With every polarity bit at 0, every timing output therefore reads 1, and both output enables read 0.
- R2: Polarity bits are indexed as 0 = field, 1 = blank, 2 = hsync, 3 = vsync, 4 = data-valid and 5 = vertical-interval data. A bit of 1 passes the captured flag unchanged and a bit of 0 inverts it. The captured flag is the raster input from the previous clock edge.
- R3: While the freeze request is high, outputs keep following the raster up to and including the cycle that carries the field-end pulse. After that cycle they hold their values.
- R4: When the freeze request is dropped, the outputs stay held until a cycle carrying the field-start pulse. The values of that cycle appear after the next edge, and normal tracking resumes from then on.
- R5: The format code is cfg_fmt, where 2 = 16-bit YCbCr, 3 = 15-bit RGB and 4 = 16-bit RGB, the wide formats. In a wide format with both data-valid controls at 0, data-valid is active only while active-video and active-line are both high. Inside that window it alternates, starting active on the first cycle of the window.
- R6: In a wide format with the duty control at 1, data-valid is active exactly when the window is open and the line-lock strobe is high.
- R7: In a wide format with the line control at 1, the window is open on every cycle, regardless of active-video and active-line.
- R8: The narrow formats are 0 = 8-bit YCbCr, 1 = byte-serial embedded-sync, and the unassigned codes 5 to 7. In these formats data-valid follows the pixel-rate strobe, and the duty control has no effect.
- R9: In a narrow format with the line control at 1, the captured data-valid is ANDed with the pixel clock before the polarity stage. With clock low it shows its inactive level.
- R10: pix_oe_o and tim_oe_o equal cfg_pix_oe and cfg_tim_oe as they were at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | FMT_W | Pixel output format code |
| cfg_pol | input | 6 | Per-output polarity selects |
| cfg_freeze | input | 1 | Freeze request |
| cfg_dv_duty | input | 1 | Data-valid duty control (wide formats) |
| cfg_dv_line | input | 1 | Data-valid line control / clock gating |
| cfg_pix_oe | input | 1 | Pixel bus drive enable request |
| cfg_tim_oe | input | 1 | Timing pin drive enable request |
| r_hsync | input | 1 | Raw horizontal sync |
| r_vsync | input | 1 | Raw vertical sync |
| r_blank | input | 1 | Raw blanking |
| r_field_odd | input | 1 | High during odd fields |
| r_active | input | 1 | Active video within the line |
| r_active_line | input | 1 | Line is an active picture line |
| r_vbi | input | 1 | Vertical-interval data present |
| r_pix_stb | input | 1 | Pixel-rate strobe |
| r_line_lock | input | 1 | Line-locked data strobe |
| r_field_end | input | 1 | One-cycle pulse on the last cycle of a field |
| r_field_start | input | 1 | One-cycle pulse on the first cycle of a field |
| hsync_o | output | 1 | Horizontal sync out |
| vsync_o | output | 1 | Vertical sync out |
| blank_o | output | 1 | Blanking out |
| field_o | output | 1 | Field indicator out |
| dvalid_o | output | 1 | Data-valid out |
| vbivalid_o | output | 1 | Vertical-interval data valid out |
| pix_oe_o | output | 1 | Pixel bus drive enable |
| tim_oe_o | output | 1 | Timing pins drive enable |

## Verification
The bench targets the freeze boundary cycles. A design that stopped one cycle early would miss the field-end values. A design that resumed on the request edge instead of the field-start pulse would show fresh timing mid-field. In the half-rate data-valid mode the bench checks the phase on entering the window: a phase left over from an earlier window would start the strobe inactive. It samples the clock-gated path in both clock phases and flips the duty bit in the narrow formats, so a stray gate or a leaking duty control shows up as a wrong level.

// File: rtl/vtof_pkg.sv
package vtof_pkg;

   // bit positions inside the polarity vector and the capture register
   localparam int SIG_FIELD = 0;
   localparam int SIG_BLANK = 1;
   localparam int SIG_HS    = 2;
   localparam int SIG_VS    = 3;
   localparam int SIG_DV    = 4;
   localparam int SIG_VBI   = 5;
   localparam int NSIG      = 6;

   // format codes; anything not listed as wide is treated as narrow
   localparam logic [2:0] FMT_Y8    = 3'd0;
   localparam logic [2:0] FMT_B656  = 3'd1;
   localparam logic [2:0] FMT_Y16   = 3'd2;
   localparam logic [2:0] FMT_RGB15 = 3'd3;
   localparam logic [2:0] FMT_RGB16 = 3'd4;

   typedef enum logic [1:0] {
      FZ_RUN  = 2'd0,
      FZ_PEND = 2'd1,
      FZ_HELD = 2'd2,
      FZ_REL  = 2'd3
   } fz_state_e;

endpackage

// File: rtl/vtof_freeze_ctl.sv
module vtof_freeze_ctl
   import vtof_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic freeze_req,
   input  logic field_end,
   input  logic field_start,
   output logic cap
);

   fz_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      cap  = 1'b0;
      case (st_q)
         FZ_RUN: begin
            cap = 1'b1;
            if (freeze_req) st_d = field_end ? FZ_HELD : FZ_PEND;
         end
         FZ_PEND: begin
            cap = 1'b1;
            if (!freeze_req)    st_d = FZ_RUN;
            else if (field_end) st_d = FZ_HELD;
         end
         FZ_HELD: begin
            if (!freeze_req) begin
               if (field_start) begin
                  cap  = 1'b1;
                  st_d = FZ_RUN;
               end else begin
                  st_d = FZ_REL;
               end
            end
         end
         FZ_REL: begin
            if (freeze_req) st_d = FZ_HELD;
            else if (field_start) begin
               cap  = 1'b1;
               st_d = FZ_RUN;
            end
         end
         default: st_d = FZ_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= FZ_RUN;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/vtof_dvalid_gen.sv
module vtof_dvalid_gen
   import vtof_pkg::*;
#(
   parameter int FMT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [FMT_W-1:0] fmt,
   input  logic             dv_duty,
   input  logic             dv_line,
   input  logic             active,
   input  logic             active_line,
   input  logic             line_lock,
   input  logic             pix_stb,
   output logic             dv_next,
   output logic             gate_en
);

   localparam logic [FMT_W-1:0] W_LO = FMT_W'(FMT_Y16);
   localparam logic [FMT_W-1:0] W_HI = FMT_W'(FMT_RGB16);

   logic wide, window, ph_q, half_rate;

   assign wide      = (fmt >= W_LO) && (fmt <= W_HI);
   assign window    = dv_line | (active & active_line);
   assign half_rate = wide & ~dv_duty & window;

   always_comb begin
      if (wide) begin
         if (dv_duty) dv_next = window & line_lock;
         else         dv_next = window & ~ph_q;
      end else begin
         dv_next = pix_stb;
      end
   end

   assign gate_en = ~wide & dv_line;

   // phase advances only while timing is being captured so a frozen
   // strobe resumes on the same phase it stopped on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ph_q <= 1'b0;
      else if (cap) ph_q <= half_rate ? ~ph_q : 1'b0;
   end

endmodule

// File: rtl/vtof_pol_stage.sv
module vtof_pol_stage #(
   parameter int N = 6
) (
   input  logic [N-1:0] raw,
   input  logic [N-1:0] pol,
   output logic [N-1:0] pin
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      assign pin[g] = pol[g] ? raw[g] : ~raw[g];
   end

endmodule

// File: rtl/vid_timing_fmt.sv
module vid_timing_fmt
   import vtof_pkg::*;
#(
   parameter int FMT_W       = 3,
   parameter bit CLK_GATE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FMT_W-1:0] cfg_fmt,
   input  logic [NSIG-1:0]  cfg_pol,
   input  logic             cfg_freeze,
   input  logic             cfg_dv_duty,
   input  logic             cfg_dv_line,
   input  logic             cfg_pix_oe,
   input  logic             cfg_tim_oe,
   input  logic             r_hsync,
   input  logic             r_vsync,
   input  logic             r_blank,
   input  logic             r_field_odd,
   input  logic             r_active,
   input  logic             r_active_line,
   input  logic             r_vbi,
   input  logic             r_pix_stb,
   input  logic             r_line_lock,
   input  logic             r_field_end,
   input  logic             r_field_start,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             blank_o,
   output logic             field_o,
   output logic             dvalid_o,
   output logic             vbivalid_o,
   output logic             pix_oe_o,
   output logic             tim_oe_o
);

   if (FMT_W < 3) begin : g_bad_fmt_w
      $error("vid_timing_fmt: FMT_W must hold codes up to 4");
   end

   logic            cap, dv_next, gate_en, dv_view;
   logic [NSIG-1:0] raw_d, raw_q, raw_v, pin;

   vtof_freeze_ctl u_fz (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze_req (cfg_freeze),
      .field_end  (r_field_end),
      .field_start(r_field_start),
      .cap        (cap)
   );

   vtof_dvalid_gen #(.FMT_W(FMT_W)) u_dv (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (cap),
      .fmt        (cfg_fmt),
      .dv_duty    (cfg_dv_duty),
      .dv_line    (cfg_dv_line),
      .active     (r_active),
      .active_line(r_active_line),
      .line_lock  (r_line_lock),
      .pix_stb    (r_pix_stb),
      .dv_next    (dv_next),
      .gate_en    (gate_en)
   );

   always_comb begin
      raw_d            = '0;
      raw_d[SIG_FIELD] = r_field_odd;
      raw_d[SIG_BLANK] = r_blank;
      raw_d[SIG_HS]    = r_hsync;
      raw_d[SIG_VS]    = r_vsync;
      raw_d[SIG_DV]    = dv_next;
      raw_d[SIG_VBI]   = r_vbi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   raw_q <= '0;
      else if (cap) raw_q <= raw_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_oe_o <= 1'b0;
         tim_oe_o <= 1'b0;
      end else begin
         pix_oe_o <= cfg_pix_oe;
         tim_oe_o <= cfg_tim_oe;
      end
   end

   if (CLK_GATE_EN) begin : g_gate
      logic gate_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gate_q <= 1'b0;
         else        gate_q <= gate_en;
      end
      assign dv_view = raw_q[SIG_DV] & (~gate_q | clk);
   end else begin : g_nogate
      assign dv_view = raw_q[SIG_DV];
   end

   always_comb begin
      raw_v         = raw_q;
      raw_v[SIG_DV] = dv_view;
   end

   vtof_pol_stage #(.N(NSIG)) u_pol (
      .raw(raw_v),
      .pol(cfg_pol),
      .pin(pin)
   );

   assign field_o    = pin[SIG_FIELD];
   assign blank_o    = pin[SIG_BLANK];
   assign hsync_o    = pin[SIG_HS];
   assign vsync_o    = pin[SIG_VS];
   assign dvalid_o   = pin[SIG_DV];
   assign vbivalid_o = pin[SIG_VBI];

endmodule

// File: rtl/vtof_chk.sv
module vtof_chk
   import vtof_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic [NSIG-1:0] cfg_pol,
   input logic            cfg_freeze,
   input logic            cfg_tim_oe,
   input logic            cfg_pix_oe,
   input logic            r_hsync,
   input logic            r_field_end,
   input logic            r_field_start,
   input logic            hsync_o,
   input logic            vsync_o,
   input logic            tim_oe_o,
   input logic            pix_oe_o,
   input logic            cap
);

   // R10
   tim_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tim_oe_o == $past(cfg_tim_oe)));

   // R10
   pix_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pix_oe_o == $past(cfg_pix_oe)));

   // R2
   hsync_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (hsync_o == (cfg_pol[SIG_HS] ? $past(r_hsync) : !$past(r_hsync))));

   // R3
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> (!$stable(cfg_pol) || $stable(vsync_o)));

   // R3
   freeze_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_freeze && r_field_end) |=> (!cap || !cfg_freeze));

   // R4
   resume_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_freeze && r_field_start) |-> cap);

endmodule

bind vid_timing_fmt vtof_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_pol      (cfg_pol),
   .cfg_freeze   (cfg_freeze),
   .cfg_tim_oe   (cfg_tim_oe),
   .cfg_pix_oe   (cfg_pix_oe),
   .r_hsync      (r_hsync),
   .r_field_end  (r_field_end),
   .r_field_start(r_field_start),
   .hsync_o      (hsync_o),
   .vsync_o      (vsync_o),
   .tim_oe_o     (tim_oe_o),
   .pix_oe_o     (pix_oe_o),
   .cap          (cap)
);

// File: tb/vid_timing_fmt_tb.sv
module vid_timing_fmt_tb;

   localparam int CLK_T = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] cfg_fmt;
   logic [5:0] cfg_pol;
   logic       cfg_freeze, cfg_dv_duty, cfg_dv_line, cfg_pix_oe, cfg_tim_oe;
   logic       r_hsync, r_vsync, r_blank, r_field_odd, r_active, r_active_line;
   logic       r_vbi, r_pix_stb, r_line_lock, r_field_end, r_field_start;
   logic       hsync_o, vsync_o, blank_o, field_o, dvalid_o, vbivalid_o;
   logic       pix_oe_o, tim_oe_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_T/2) clk = ~clk;

   vid_timing_fmt u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_pol(cfg_pol),
      .cfg_freeze(cfg_freeze), .cfg_dv_duty(cfg_dv_duty), .cfg_dv_line(cfg_dv_line),
      .cfg_pix_oe(cfg_pix_oe), .cfg_tim_oe(cfg_tim_oe),
      .r_hsync(r_hsync), .r_vsync(r_vsync), .r_blank(r_blank),
      .r_field_odd(r_field_odd), .r_active(r_active), .r_active_line(r_active_line),
      .r_vbi(r_vbi), .r_pix_stb(r_pix_stb), .r_line_lock(r_line_lock),
      .r_field_end(r_field_end), .r_field_start(r_field_start),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o), .field_o(field_o),
      .dvalid_o(dvalid_o), .vbivalid_o(vbivalid_o),
      .pix_oe_o(pix_oe_o), .tim_oe_o(tim_oe_o)
   );

   function automatic logic pexp(input logic p, input logic v);
      return p ? v : ~v;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // inputs change a quarter period after the rising edge; samples are taken there too
   task automatic tick();
      @(posedge clk);
      #(CLK_T/4);
   endtask

   task automatic raster_idle();
      r_hsync = 0; r_vsync = 0; r_blank = 0; r_field_odd = 0; r_active = 0;
      r_active_line = 0; r_vbi = 0; r_pix_stb = 0; r_line_lock = 0;
      r_field_end = 0; r_field_start = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      cfg_fmt = 3'd0; cfg_pol = '0; cfg_freeze = 0; cfg_dv_duty = 0; cfg_dv_line = 0;
      cfg_pix_oe = 0; cfg_tim_oe = 0;
      raster_idle();
      repeat (3) @(posedge clk);
      #(CLK_T/4);
      chk("R1 hsync in reset", hsync_o, 1'b1);
      chk("R1 dvalid in reset", dvalid_o, 1'b1);
      chk("R1 pix_oe in reset", pix_oe_o, 1'b0);
      chk("R1 tim_oe in reset", tim_oe_o, 1'b0);
      rst_n = 1;
      tick();
      chk("R1 field after reset", field_o, 1'b1);
      chk("R1 vbi after reset", vbivalid_o, 1'b1);
      chk("R1 tim_oe after reset", tim_oe_o, 1'b0);
   endtask

   task automatic t_oe();
      cfg_pix_oe = 1; cfg_tim_oe = 0;
      tick();
      chk("R10 pix_oe on", pix_oe_o, 1'b1);
      chk("R10 tim_oe off", tim_oe_o, 1'b0);
      cfg_pix_oe = 0; cfg_tim_oe = 1;
      tick();
      chk("R10 pix_oe off", pix_oe_o, 1'b0);
      chk("R10 tim_oe on", tim_oe_o, 1'b1);
   endtask

   task automatic t_polarity();
      logic [5:0] pats [4] = '{6'b000000, 6'b111111, 6'b101010, 6'b010101};
      cfg_fmt = 3'd0;
      for (int p = 0; p < 4; p++) begin
         cfg_pol = pats[p];
         for (int i = 0; i < 4; i++) begin
            logic a, b;
            a = i[0]; b = i[1];
            r_field_odd = a; r_blank = b; r_hsync = a ^ b; r_vsync = ~a;
            r_pix_stb = b; r_vbi = ~b;
            tick();
            chk("R2 field", field_o, pexp(cfg_pol[0], a));
            chk("R2 blank", blank_o, pexp(cfg_pol[1], b));
            chk("R2 hsync", hsync_o, pexp(cfg_pol[2], a ^ b));
            chk("R2 vsync", vsync_o, pexp(cfg_pol[3], ~a));
            chk("R2 dvalid", dvalid_o, pexp(cfg_pol[4], b));
            chk("R2 vbivalid", vbivalid_o, pexp(cfg_pol[5], ~b));
         end
      end
      raster_idle();
   endtask

   task automatic t_freeze();
      cfg_pol = 6'b111111; cfg_fmt = 3'd0;
      r_hsync = 1; tick();
      chk("R3 running", hsync_o, 1'b1);
      cfg_freeze = 1; r_hsync = 0; tick();
      chk("R3 pending still tracks", hsync_o, 1'b0);
      r_hsync = 1; r_vsync = 1; r_field_end = 1; tick();
      chk("R3 field-end values captured", hsync_o, 1'b1);
      chk("R3 field-end vsync captured", vsync_o, 1'b1);
      r_field_end = 0; r_hsync = 0; r_vsync = 0; tick();
      chk("R3 held hsync", hsync_o, 1'b1);
      chk("R3 held vsync", vsync_o, 1'b1);
      tick();
      chk("R3 still held", hsync_o, 1'b1);
      cfg_freeze = 0; tick();
      chk("R4 held after release", hsync_o, 1'b1);
      tick();
      chk("R4 held until field start", vsync_o, 1'b1);
      r_field_start = 1; tick();
      chk("R4 field-start values shown", hsync_o, 1'b0);
      chk("R4 field-start vsync shown", vsync_o, 1'b0);
      r_field_start = 0; r_hsync = 1; tick();
      chk("R4 tracking resumed", hsync_o, 1'b1);
      raster_idle();
      tick();
   endtask

   task automatic t_wide_half();
      logic exp_seq [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      cfg_pol = 6'b111111; cfg_fmt = 3'd2; cfg_dv_duty = 0; cfg_dv_line = 0;
      raster_idle(); tick();
      chk("R5 closed window", dvalid_o, 1'b0);
      r_active = 1; r_active_line = 1;
      for (int i = 0; i < 6; i++) begin
         tick();
         chk("R5 half-rate strobe", dvalid_o, exp_seq[i]);
      end
      r_active_line = 0; tick();
      chk("R5 inactive line", dvalid_o, 1'b0);
      cfg_fmt = 3'd4; r_active_line = 1; tick();
      chk("R5 rgb16 first", dvalid_o, 1'b1);
      tick();
      chk("R5 rgb16 second", dvalid_o, 1'b0);
      raster_idle(); tick();
   endtask

   task automatic t_wide_lock();
      logic ll [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
      cfg_fmt = 3'd3; cfg_dv_duty = 1; cfg_dv_line = 0;
      r_active = 1; r_active_line = 1;
      for (int i = 0; i < 4; i++) begin
         r_line_lock = ll[i];
         tick();
         chk("R6 line-lock follows", dvalid_o, ll[i]);
      end
      r_active = 0; r_line_lock = 1; tick();
      chk("R6 window closed", dvalid_o, 1'b0);
      cfg_dv_line = 1; tick();
      chk("R7 whole line with line-lock", dvalid_o, 1'b1);
      cfg_dv_duty = 0; r_line_lock = 0; r_active = 0; r_active_line = 0;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R7 whole line half-rate", dvalid_o, (i % 2 == 0) ? 1'b1 : 1'b0);
      end
      cfg_dv_line = 0; raster_idle(); tick();
   endtask

   task automatic t_narrow();
      logic ps [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
      logic [2:0] fm [3] = '{3'd0, 3'd1, 3'd6};
      cfg_dv_line = 0;
      for (int f = 0; f < 3; f++) begin
         cfg_fmt = fm[f];
         for (int i = 0; i < 4; i++) begin
            cfg_dv_duty = i[0];
            r_pix_stb = ps[i];
            r_line_lock = ~ps[i];
            tick();
            chk("R8 narrow follows strobe", dvalid_o, ps[i]);
         end
      end
      cfg_dv_duty = 0; raster_idle(); tick();
   endtask

   task automatic t_gate();
      cfg_fmt = 3'd1; cfg_dv_line = 1; cfg_pol[4] = 1; r_pix_stb = 1;
      tick();
      chk("R9 gated, clock high", dvalid_o, 1'b1);
      #(CLK_T/2);
      chk("R9 gated, clock low", dvalid_o, 1'b0);
      cfg_pol[4] = 0;
      tick();
      chk("R9 gated low-active, clock high", dvalid_o, 1'b0);
      #(CLK_T/2);
      chk("R9 gated low-active, clock low", dvalid_o, 1'b1);
      cfg_pol[4] = 1; r_pix_stb = 0;
      tick();
      chk("R9 gated idle", dvalid_o, 1'b0);
      cfg_dv_line = 0; r_pix_stb = 1;
      tick();
      chk("R9 ungated, clock high", dvalid_o, 1'b1);
      #(CLK_T/2);
      chk("R9 ungated, clock low", dvalid_o, 1'b1);
      raster_idle();
   endtask

   initial begin
      t_reset();
      t_oe();
      t_polarity();
      t_freeze();
      t_wide_half();
      t_wide_lock();
      t_narrow();
      t_gate();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_T * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule